// File: doc/BRIEF.md
# Address-then-Data Serial Transmitter

This block sends a two-part frame on one serial data line while generating its own serial clock. One part is an address byte and the other is a data byte. A requester presents an address and a data value together with a valid strobe. The transmitter accepts the pair when it is idle and copies both values into internal holding registers. It then shifts out the address bits, inserts a quiet gap slot, shifts out the data bits and returns to idle. A one-cycle completion pulse marks the end of the frame.

The serial clock is the system clock divided by `CLK_DIV` (4 by default). It is low for the first half of each bit slot and high for the second half. Each bit is placed on the line when its slot begins, which is also when the serial clock falls. The bit is therefore settled well before the receiver samples it on the rising serial edge. The request side uses a valid/ready handshake. `req_ready` is high exactly while the transmitter is idle, and a transfer is accepted on a clock edge where `req_valid` and `req_ready` are both high. A requester that keeps `req_valid` asserted while the transmitter is busy is stalled, and it is accepted in the first cycle the transmitter is idle again. A valid that is dropped before that cycle leaves no trace.

Top module: `atd_serial_tx`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1.
- R2: The address phase begins in the cycle after acceptance. It sends the 8 address bits least significant bit first, and bit i is driven on `sdo` for the 4 system cycles of serial slot i.
- R3: During the address and data phases, `sclk` is low for 2 system cycles and then high for 2 system cycles in every slot. `sclk` is low while idle and during the gap.
- R4: Between the two phases there is exactly one gap slot of 4 system cycles, with `sclk` and `sdo` both low.
- R5: The data phase follows the gap. It sends the 8 data bits least significant bit first with the same slot timing as the address phase.
- R6: `sdo` changes only in a cycle where `sclk` is low, so it never changes while `sclk` is high.
- R7: The address and data values are captured at acceptance. Changes on `req_addr` and `req_data` during a transfer do not alter the transmitted frame.
- R8: `busy` rises in the cycle after acceptance and stays high for exactly 68 system cycles (32 address, 4 gap, 32 data).
- R9: A `req_valid` pulse that ends while `busy` is high is ignored. It neither restarts nor extends the frame, and it does not queue a second frame.
- R10: `done` is high for exactly one cycle: the first cycle after the last data slot, in which `busy` is already low.
- R11: While synchronous active-high `rst` is sampled high, the block returns to idle at the next edge, with `sclk`, `sdo`, `busy` and `done` low and `req_ready` high. This holds even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request strobe |
| req_ready | output | 1 | High while a request can be accepted |
| req_addr | input | ADDR_W | Address byte to send |
| req_data | input | DATA_W | Data byte to send |
| busy | output | 1 | High from acceptance until the frame ends |
| done | output | 1 | One-cycle frame completion pulse |
| sclk | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial data line |

## Verification
The hardest situations to reach are around the edges of a frame. One is a request that arrives while the transmitter is busy. Another is a requester that holds valid across the end of a frame, so that the next frame starts right after the done cycle. A third is a reset that lands in the middle of a frame. The stimulus creates all three directly. It pulses valid with new input values in the middle of the address phase. It holds valid steadily across two complete frames. It raises reset while the transmitter is busy. A behavioural model tracks the expected position in the frame and compares every output on every cycle.

// File: rtl/atd_pkg.sv
package atd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } atd_state_e;
endpackage

// File: rtl/atd_sclk_gen.sv
// Slot timer and serial clock: each slot lasts DIV system cycles,
// clock low in the first half and high in the second.
module atd_sclk_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic drive,
  output logic sclk,
  output logic slot_end
);
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam int LAST = DIV - 1;

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !run) ph <= '0;
    else if (ph == PW'(LAST)) ph <= '0;
    else ph <= ph + 1'b1;
  end

  assign slot_end = run && (ph == PW'(LAST));
  assign sclk     = drive && (ph >= PW'(HALF));

  // falling serial edges line up with the start of a slot
  assert_fall_at_slot_start_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (ph == '0));
endmodule

// File: rtl/atd_bit_counter.sv
// Bit index inside a phase; wraps to zero on the last bit of the phase.
module atd_bit_counter #(
  parameter int MAXW = 8,
  parameter int IW   = (MAXW > 1) ? $clog2(MAXW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [IW-1:0] limit,
  output logic [IW-1:0] idx,
  output logic          last_bit
);
  always_ff @(posedge clk) begin
    if (rst || clear) idx <= '0;
    else if (step) idx <= (idx == limit) ? '0 : idx + 1'b1;
  end

  assign last_bit = step && (idx == limit);

  assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    idx <= limit);
endmodule

// File: rtl/atd_fsm.sv
module atd_fsm
  import atd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_fire,
  input  logic       slot_end,
  input  logic       phase_last,
  output atd_state_e state,
  output logic       done
);
  atd_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req_fire)   nxt = ST_ADDR;
      ST_ADDR: if (phase_last) nxt = ST_GAP;
      ST_GAP:  if (slot_end)   nxt = ST_DATA;
      ST_DATA: if (phase_last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_DATA) && phase_last;
    end
  end

  assert_gap_after_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> ($past(state) == ST_ADDR || $past(state) == ST_GAP));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_after_data_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE && $past(state) == ST_DATA));
endmodule

// File: rtl/atd_serial_tx.sv
module atd_serial_tx
  import atd_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              sdo
);
  localparam int MAXW = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int IW   = (MAXW > 1) ? $clog2(MAXW) : 1;

  atd_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     limit;
  logic              shifting, running, slot_end, last_bit, req_fire;

  assign req_ready = (state == ST_IDLE);
  assign busy      = !req_ready;
  assign req_fire  = req_valid && req_ready;
  assign running   = (state != ST_IDLE);
  assign shifting  = (state == ST_ADDR) || (state == ST_DATA);
  assign limit     = (state == ST_DATA) ? IW'(DATA_W - 1) : IW'(ADDR_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (req_fire) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  atd_sclk_gen #(.DIV(CLK_DIV)) u_clkgen (
    .clk(clk), .rst(rst), .run(running), .drive(shifting),
    .sclk(sclk), .slot_end(slot_end)
  );

  atd_bit_counter #(.MAXW(MAXW), .IW(IW)) u_bitcnt (
    .clk(clk), .rst(rst), .clear(!shifting), .step(slot_end && shifting),
    .limit(limit), .idx(idx), .last_bit(last_bit)
  );

  atd_fsm u_fsm (
    .clk(clk), .rst(rst), .req_fire(req_fire), .slot_end(slot_end),
    .phase_last(last_bit), .state(state), .done(done)
  );

  always_comb begin
    unique case (state)
      ST_ADDR: sdo = addr_q[idx];
      ST_DATA: sdo = data_q[idx];
      default: sdo = 1'b0;
    endcase
  end

  assert_sclk_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_GAP) |-> !sclk);
  assert_sdo_hold_high_R6: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdo));
  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));
  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> (state != ST_ADDR || $past(state) == ST_ADDR));
  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> (!busy && !sclk && !sdo && !done));
endmodule

// File: tb/tb_atd_serial_tx.sv
`timescale 1ns/1ps
module tb_atd_serial_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_data = 8'h00;
  logic req_ready, busy, done, sclk, sdo;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  atd_serial_tx dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .sclk(sclk), .sdo(sdo)
  );

  // behavioural model: position inside a 68-cycle frame, -1 when idle
  int m_pos = -1;
  logic m_done = 1'b0;
  logic [7:0] m_a = 8'h00, m_d = 8'h00;
  bit started = 1'b0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_pos  = -1;
      m_done = 1'b0;
    end else if (m_pos >= 0) begin
      m_done = 1'b0;
      if (m_pos == 67) begin m_pos = -1; m_done = 1'b1; end
      else m_pos = m_pos + 1;
    end else begin
      m_done = 1'b0;
      if (req_valid) begin m_pos = 0; m_a = req_addr; m_d = req_data; end
    end
  end

  function automatic logic exp_sclk(int p);
    if (p >= 0 && p < 32) return (p % 4) >= 2;
    if (p >= 36 && p < 68) return ((p - 36) % 4) >= 2;
    return 1'b0;
  endfunction

  function automatic logic exp_sdo(int p, logic [7:0] a, logic [7:0] d);
    if (p >= 0 && p < 32) return a[p / 4];
    if (p >= 36 && p < 68) return d[(p - 36) / 4];
    return 1'b0;
  endfunction

  function automatic string sdo_tag(int p);
    if (p >= 0 && p < 32) return "R2";
    if (p >= 32 && p < 36) return "R4";
    if (p >= 36) return "R5";
    return "R11";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, expv);
    end
  endtask

  logic prev_sclk = 1'b0, prev_sdo = 1'b0;

  always @(negedge clk) begin
    if (started) begin
      check(sclk == exp_sclk(m_pos), "R3 sclk", int'(sclk), int'(exp_sclk(m_pos)));
      check(sdo == exp_sdo(m_pos, m_a, m_d), sdo_tag(m_pos), int'(sdo),
            int'(exp_sdo(m_pos, m_a, m_d)));
      check(busy == (m_pos >= 0), "R8 busy", int'(busy), int'(m_pos >= 0));
      check(req_ready == (m_pos < 0), "R1 ready", int'(req_ready), int'(m_pos < 0));
      check(done == m_done, "R10 done", int'(done), int'(m_done));
      // R6: line never moves while the serial clock stays high
      if (prev_sclk && sclk)
        check(sdo == prev_sdo, "R6 sdo moved while sclk high", int'(sdo), int'(prev_sdo));
      prev_sclk = sclk;
      prev_sdo  = sdo;
    end
  end

  task automatic send(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);           // R11 reset state observed
    send(8'hA5, 8'h3C);
    repeat (10) @(negedge clk);
    // R7 and R9: new values and a valid pulse while busy
    req_addr = 8'hFF; req_data = 8'h00; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (70) @(negedge clk);
    // R1 back-pressure: valid held across two frames
    req_valid = 1'b1; req_addr = 8'h01; req_data = 8'h80;
    repeat (40) @(negedge clk);
    req_addr = 8'h6E; req_data = 8'h93;  // applies only to the queued second frame
    repeat (100) @(negedge clk);
    req_valid = 1'b0;
    repeat (80) @(negedge clk);
    send(8'hFF, 8'h00);
    repeat (40) @(negedge clk);
    rst = 1'b1;                          // R11 mid-frame reset
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    send(8'h80, 8'h01);
    repeat (75) @(negedge clk);
    send(8'h00, 8'hFF);
    repeat (75) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule